// File: doc/BRIEF.md
# Presettable Up/Down Decade or Binary Counter

This block is a 4-bit synchronous up/down counter. A parameter selects decade counting (0 to 9) or binary counting (0 to 15). The counter advances on the rising clock edge when its active-low enable is asserted. A direction input selects the counting direction. An active-low load input forces the count to a preset value at once, without waiting for a clock edge, and load takes precedence over every other input.

Two outputs support cascading. The terminal flag is active high. It is decoded combinationally from the count and the direction, and it marks the last state before a wrap, so the next stage can use it as a fast look-ahead carry. The ripple strobe is active low and is a slower cascade signal. It pulses low during the low half of the clock, but only while the terminal flag is set and counting is enabled.

In decade mode the counter can be loaded with 10 to 15. From any of these states it returns to the legal 0 to 9 cycle within one or two counts, in either direction.

Top module: `updn_preset_ctr`

## Requirements
- R1: While `load_n` is 0, `count_o` equals `preset_i` at once, with no clock edge needed. Load overrides reset, enable and direction. After `load_n` returns to 1, the count holds the preset value until the next enabled edge.
- R2: With `load_n`=1, `rst`=0 and `cnt_en_n`=0, each rising clock edge moves the count by one. The count goes up when `down_i`=0 and down when `down_i`=1.
- R3: With `load_n`=1 and `cnt_en_n`=1, the count does not change across clock edges.
- R4: Decade mode wraps 9 to 0 when counting up and 0 to 9 when counting down. Binary mode wraps 15 to 0 and 0 to 15.
- R5: `term_o` is 1 exactly when the count is at the mode maximum (9 or 15) with `down_i`=0, or at 0 with `down_i`=1. `cnt_en_n` does not affect it.
- R6: `ripple_n_o` is 0 only while `clk` is low, `term_o` is 1 and `cnt_en_n` is 0. It is 1 at all other times, including the whole high half of every clock period.
- R7: In decade mode, counting up moves 11, 13 and 15 to 0, and moves 10, 12 and 14 to the next value. Counting down moves 11, 13 and 15 to the previous value, and moves 10, 12 and 14 to 9.
- R8: With `load_n`=1, `rst`=1 at a rising edge clears the count to 0.
- R9: With `DECADE`=0, the block counts the full binary range 0 to 15, and R2 to R5 apply with a maximum of 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low immediate preset |
| preset_i | input | 4 | Value taken while `load_n` is low |
| cnt_en_n | input | 1 | Active-low count enable |
| down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| count_o | output | 4 | Current count |
| term_o | output | 1 | Active-high terminal flag (maximum going up, zero going down) |
| ripple_n_o | output | 1 | Active-low strobe during the clock low phase at terminal count |

## Verification
Some rules are checked by assertions on every clock edge:
- the count equals the preset while load is low;
- the count is held while the counter is disabled;
- a legal decade count never leaves 0 to 9;
- an illegal decade state always moves toward the legal cycle;
- the terminal flag is set only at 0 or at the maximum;
- the ripple strobe is high whenever the clock is high.

Other behaviour is shown only by the bench scenarios, which run a decade counter and a binary counter side by side:
- the exact counting sequences;
- the wrap points;
- the value seen at once after a load, between clock edges;
- the one-cycle width of the terminal pulse;
- the ripple strobe in the clock low phase.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

    localparam int CW      = 4;
    localparam int DEC_MAX = 9;
    localparam int BIN_MAX = (1 << CW) - 1;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic active;
        dir_e dir;
    } step_req_t;

    function automatic cnt_t bin_next(input cnt_t cur, input dir_e dir);
        return (dir == DIR_UP) ? cnt_t'(cur + 1'b1) : cnt_t'(cur - 1'b1);
    endfunction

    function automatic cnt_t dec_next(input cnt_t cur, input dir_e dir);
        cnt_t res;
        if (dir == DIR_UP) begin
            if (cur == cnt_t'(DEC_MAX))     res = '0;
            else if (cur < cnt_t'(DEC_MAX)) res = cnt_t'(cur + 1'b1);
            else if (cur[0])                res = '0;
            else                            res = cnt_t'(cur + 1'b1);
        end else begin
            if (cur == '0)                  res = cnt_t'(DEC_MAX);
            else if (cur <= cnt_t'(DEC_MAX)) res = cnt_t'(cur - 1'b1);
            else if (cur[0])                res = cnt_t'(cur - 1'b1);
            else                            res = cnt_t'(DEC_MAX);
        end
        return res;
    endfunction

endpackage

// File: rtl/updn_ctr_next.sv
module updn_ctr_next
    import updn_ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  cnt_t cur,
    input  dir_e dir,
    output cnt_t nxt
);
    localparam int TOP = DECADE ? DEC_MAX : BIN_MAX;

    generate
        if (DECADE) begin : g_dec
            assign nxt = dec_next(cur, dir);
        end else begin : g_bin
            assign nxt = bin_next(cur, dir);
        end
    endgenerate

    // R4: a legal count never steps out of the legal range
    p_legal_stays_r4: assert property (@(posedge clk) disable iff (rst)
        (cur <= cnt_t'(TOP)) |-> (nxt <= cnt_t'(TOP)));

    generate
        if (DECADE) begin : g_dec_chk
            // R7: upward from an illegal state lands legal or on an odd illegal value
            p_up_recover_r7: assert property (@(posedge clk) disable iff (rst)
                (cur > cnt_t'(DEC_MAX) && dir == DIR_UP) |-> (nxt <= cnt_t'(DEC_MAX) || nxt[0]));
            // R7: downward from an illegal state lands legal or on an even illegal value
            p_dn_recover_r7: assert property (@(posedge clk) disable iff (rst)
                (cur > cnt_t'(DEC_MAX) && dir == DIR_DOWN) |-> (nxt <= cnt_t'(DEC_MAX) || !nxt[0]));
        end
    endgenerate
endmodule

// File: rtl/updn_ctr_term.sv
module updn_ctr_term
    import updn_ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  cnt_t cur,
    input  dir_e dir,
    input  logic en_n,
    output logic term,
    output logic ripple_n
);
    localparam cnt_t TOP = cnt_t'(DECADE ? DEC_MAX : BIN_MAX);

    logic at_top, at_zero;

    always_comb begin
        at_top   = (cur == TOP);
        at_zero  = (cur == '0);
        term     = (dir == DIR_UP) ? at_top : at_zero;
        ripple_n = !(term && !en_n && !clk);
    end

    // R5: the flag only ever marks one of the two end states
    p_term_ends_r5: assert property (@(posedge clk) disable iff (rst)
        term |-> (cur == TOP || cur == '0));

    // R6: sampled just before the falling edge the clock is high, so the strobe must be idle
    p_ripple_idle_r6: assert property (@(negedge clk) disable iff (rst)
        ripple_n);

    // R6: a low strobe implies an enabled counter at terminal count
    p_ripple_cause_r6: assert property (@(posedge clk) disable iff (rst)
        !ripple_n |-> (term && !en_n));
endmodule

// File: rtl/updn_preset_ctr.sv
module updn_preset_ctr
    import updn_ctr_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_n,
    input  logic [3:0] preset_i,
    input  logic       cnt_en_n,
    input  logic       down_i,
    output logic [3:0] count_o,
    output logic       term_o,
    output logic       ripple_n_o
);
    step_req_t req;
    cnt_t      cnt_q;
    cnt_t      cnt_nxt;
    cnt_t      shown;

    assign req.active = !cnt_en_n;
    assign req.dir    = dir_e'(down_i);

    updn_ctr_next #(.DECADE(DECADE)) u_next (
        .clk (clk),
        .rst (rst),
        .cur (shown),
        .dir (req.dir),
        .nxt (cnt_nxt)
    );

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)         cnt_q <= cnt_t'(preset_i);
        else if (rst)        cnt_q <= '0;
        else if (req.active) cnt_q <= cnt_nxt;
    end

    assign shown   = load_n ? cnt_q : cnt_t'(preset_i);
    assign count_o = shown;

    updn_ctr_term #(.DECADE(DECADE)) u_term (
        .clk      (clk),
        .rst      (rst),
        .cur      (shown),
        .dir      (req.dir),
        .en_n     (cnt_en_n),
        .term     (term_o),
        .ripple_n (ripple_n_o)
    );

    // R1: while load is held the output shows the preset value
    p_load_shows_r1: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> (count_o == preset_i));

    // R3: a disabled counter keeps its value over an edge
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en_n) |=> (!load_n || $stable(count_o)));

    // R8: synchronous clear when no load is pending
    p_clear_r8: assert property (@(posedge clk)
        (rst && load_n) |=> (!load_n || count_o == '0));
endmodule

// File: tb/test_updn_preset_ctr.sv
module test_updn_preset_ctr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] preset = 4'd0;
    logic       cnt_en_n = 1'b1;
    logic       down = 1'b0;
    logic [3:0] cnt_d, cnt_b;
    logic       term_d, term_b, rip_d, rip_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int m_d = 0;
    int m_b = 0;

    always #5 clk = ~clk;

    updn_preset_ctr #(.DECADE(1'b1)) i_updn_preset_ctr (
        .clk(clk), .rst(rst), .load_n(load_n), .preset_i(preset),
        .cnt_en_n(cnt_en_n), .down_i(down),
        .count_o(cnt_d), .term_o(term_d), .ripple_n_o(rip_d));

    updn_preset_ctr #(.DECADE(1'b0)) i_updn_preset_ctr_bin (
        .clk(clk), .rst(rst), .load_n(load_n), .preset_i(preset),
        .cnt_en_n(cnt_en_n), .down_i(down),
        .count_o(cnt_b), .term_o(term_b), .ripple_n_o(rip_b));

    function automatic int model_next(int v, bit d, bit dec);
        int top = dec ? 9 : 15;
        if (!dec) return d ? (v + 15) % 16 : (v + 1) % 16;
        if (!d) begin
            if (v <= top) return (v + 1) % 10;
            return (v % 2 == 1) ? 0 : v + 1;
        end
        if (v == 0) return 9;
        if (v <= top) return v - 1;
        return (v % 2 == 1) ? v - 1 : 9;
    endfunction

    function automatic bit model_term(int v, bit d, bit dec);
        return d ? (v == 0) : (v == (dec ? 9 : 15));
    endfunction

    function automatic string tag_of(bit ld_n, bit r, bit e_n, bit d, int prev, bit dec);
        int top = dec ? 9 : 15;
        if (!ld_n) return "R1";
        if (r) return "R8";
        if (e_n) return "R3";
        if (dec && prev > 9) return "R7";
        if ((!d && prev == top) || (d && prev == 0)) return "R4";
        return "R2";
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(bit ld_n, bit r, bit e_n, bit d, logic [3:0] p);
        int sd, sb;
        string td, tb;
        @(negedge clk);
        load_n = ld_n; rst = r; cnt_en_n = e_n; down = d; preset = p;
        #1;
        sd = ld_n ? m_d : int'(p);
        sb = ld_n ? m_b : int'(p);
        check(cnt_d == 4'(sd), ld_n ? "R2 shown" : "R1 immediate", cnt_d, sd);
        check(cnt_b == 4'(sb), ld_n ? "R9 shown" : "R9 R1 immediate", cnt_b, sb);
        check(term_d == model_term(sd, d, 1'b1), "R5 term", term_d, model_term(sd, d, 1'b1));
        check(term_b == model_term(sb, d, 1'b0), "R9 R5 term", term_b, model_term(sb, d, 1'b0));
        check(rip_d == !(model_term(sd, d, 1'b1) && !e_n), "R6 ripple low phase", rip_d,
              !(model_term(sd, d, 1'b1) && !e_n));
        check(rip_b == !(model_term(sb, d, 1'b0) && !e_n), "R9 R6 ripple low phase", rip_b,
              !(model_term(sb, d, 1'b0) && !e_n));
        @(posedge clk);
        td = tag_of(ld_n, r, e_n, d, m_d, 1'b1);
        tb = {"R9 ", tag_of(ld_n, r, e_n, d, m_b, 1'b0)};
        if (!ld_n) begin m_d = int'(p); m_b = int'(p); end
        else if (r) begin m_d = 0; m_b = 0; end
        else if (!e_n) begin m_d = model_next(m_d, d, 1'b1); m_b = model_next(m_b, d, 1'b0); end
        #1;
        check(cnt_d == 4'(m_d), td, cnt_d, m_d);
        check(cnt_b == 4'(m_b), tb, cnt_b, m_b);
        check(rip_d == 1'b1 && rip_b == 1'b1, "R6 high phase", {rip_d, rip_b}, 3);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(cnt_d == 4'd0 && cnt_b == 4'd0, "R8 reset state", cnt_d, 0);

        // Decade directed: load 7, up five, inhibit, down five
        tick(0, 0, 1, 0, 4'd7);
        tick(1, 0, 0, 0, 4'd0);
        tick(1, 0, 0, 0, 4'd0);
        check(cnt_d == 4'd9 && term_d == 1'b1, "R5 term at 9 going up", term_d, 1);
        tick(1, 0, 0, 0, 4'd0);
        check(cnt_d == 4'd0 && term_d == 1'b0, "R4 decade wrap to 0", cnt_d, 0);
        tick(1, 0, 0, 0, 4'd0);
        tick(1, 0, 0, 0, 4'd0);
        tick(1, 0, 1, 0, 4'd9);
        tick(1, 0, 1, 1, 4'd9);
        check(cnt_d == 4'd2, "R3 inhibit holds", cnt_d, 2);
        tick(1, 0, 0, 1, 4'd0);
        tick(1, 0, 0, 1, 4'd0);
        check(cnt_d == 4'd0 && term_d == 1'b1, "R5 term at 0 going down", term_d, 1);
        tick(1, 0, 0, 1, 4'd0);
        check(cnt_d == 4'd9, "R4 decade wrap to 9", cnt_d, 9);
        tick(1, 0, 0, 1, 4'd0);
        tick(1, 0, 0, 1, 4'd0);
        check(cnt_d == 4'd7, "R2 back to 7", cnt_d, 7);

        // Binary directed: load 13, up five, inhibit, down five
        tick(0, 0, 0, 1, 4'd13);
        for (int i = 0; i < 5; i++) tick(1, 0, 0, 0, 4'd0);
        check(cnt_b == 4'd2, "R9 binary up through wrap", cnt_b, 2);
        tick(1, 0, 1, 0, 4'd0);
        for (int i = 0; i < 5; i++) tick(1, 0, 0, 1, 4'd0);
        check(cnt_b == 4'd13, "R9 binary down through wrap", cnt_b, 13);

        // Load overrides reset and enable
        tick(0, 1, 0, 0, 4'd5);
        check(cnt_d == 4'd5, "R1 load beats reset", cnt_d, 5);

        // Illegal decade states, both directions, two steps each
        for (int v = 10; v < 16; v++) begin
            for (int d = 0; d < 2; d++) begin
                tick(0, 0, 1, 1'(d), 4'(v));
                tick(1, 0, 0, 1'(d), 4'd0);
                tick(1, 0, 0, 1'(d), 4'd0);
                check(cnt_d <= 4'd9, "R7 legal within two counts", cnt_d, 9);
            end
        end

        tick(1, 1, 0, 0, 4'd0);
        check(cnt_d == 4'd0 && cnt_b == 4'd0, "R8 synchronous clear", cnt_d, 0);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            bit ld_n, r, e_n, d;
            ld_n = ($urandom_range(0, 11) != 0);
            r    = ($urandom_range(0, 39) == 0);
            e_n  = ($urandom_range(0, 3) == 0);
            d    = 1'($urandom_range(0, 1));
            tick(ld_n, r, e_n, d, 4'($urandom_range(0, 15)));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule